// File: doc/BRIEF.md
# Combined forward/inverse AES substitution box (tower-field datapath)

This block is a purely combinational byte substitution unit for AES. One input byte and one direction bit go in, and the substituted byte comes out. When the direction bit is low it computes the cipher-direction substitution. When the bit is high it computes the decipher-direction substitution. There is no storage of 256 entries. The only nonlinear step, the multiplicative inverse in GF(2^8), is built from small-field arithmetic, and both directions share it.

On the input side the byte is carried into a GF(((2^2)^2)^2) representation by a constant 8x8 binary matrix. In the decipher direction this matrix is pre-merged with the inverse affine matrix, and its constant is folded in as well. The inverter then does three things: it reduces the element to one GF(2^4) value by a norm-like exponentiation, inverts that value with a GF(2^2)-based subfield inverter, and recovers both halves of the result by GF(2^4) multiplications. A second constant matrix carries the result back to the AES polynomial basis. In the cipher direction this matrix is merged with the forward affine matrix and its constant. All basis-change matrices are derived when the design is elaborated from the chosen subfield polynomials, so none of them is typed in by hand.

The block is meant to be instantiated, for example sixteen times, inside a round datapath that supplies registers around it.

Top module: `aes_sbox_dual`

## Requirements
- R1: With `inv_mode` = 0, `dout` equals the standard AES forward S-box value of `din` for all 256 values of `din`.
- R2: With `inv_mode` = 1, `dout` equals the standard AES inverse S-box value of `din` for all 256 values of `din`.
- R3: With `inv_mode` = 0 and `din` = 0x00, `dout` is 0x63.
- R4: With `inv_mode` = 1 and `din` = 0x63, `dout` is 0x00.
- R5: The block holds no state. `dout` depends only on the present `din` and `inv_mode`, and it does not change while they are held, however many clock periods pass.
- R6: The two directions are mutual inverses. Feeding the forward result of any byte back in with `inv_mode` = 1 returns the original byte.
- R7: The shared GF(2^8) inverter returns 0 for input 0. For any nonzero input, its output multiplied by that input gives 1 in the tower field. The same holds for the GF(2^4) subfield inverter within its field.
- R8: The direction bit is encoded as 0 for forward and 1 for inverse. With `din` held fixed, changing `inv_mode` alone switches `dout` between the two tables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 8 | Byte to substitute, AES polynomial basis |
| inv_mode | input | 1 | 0 = forward substitution, 1 = inverse substitution |
| dout | output | 8 | Substituted byte, AES polynomial basis |

## Verification
Forward and inverse substitution both pass through the one shared inverter, selected only by `inv_mode`. To make both directions meet on the same byte, the bench holds `din` steady and flips `inv_mode`. It then judges each result against a forward table and an inverse table. The bench builds both tables from polynomial-basis arithmetic, with a brute-force inverse and the affine equations. The round trip, forward then inverse with the first output fed back, exercises both paths on one value in consecutive steps. Full sweeps in both modes cover the zero and 0x63 corners, where the inverter's zero case matters.

// File: rtl/aes_tower_pkg.sv
// Package: tower-field arithmetic GF(((2^2)^2)^2) and the constant
// basis-change matrices, derived at elaboration.
// Assumes: GF(2^2) uses w^2+w+1, GF(2^4) uses z^2+z+NU,
// GF(2^8) uses y^2+y+LAMBDA. Bit layout of a tower byte is
// {hi GF16 {hi GF4, lo GF4}, lo GF16 {hi GF4, lo GF4}}.
// A matrix is 64 bits wide; bits [8*i +: 8] hold column i, the image of input bit i.
package aes_tower_pkg;

    typedef logic [7:0]  byte_t;
    typedef logic [63:0] mat_t;

    localparam logic [1:0] NU = 2'b10;

    // GF(2^2) product in basis {w, 1}
    function automatic logic [1:0] gf4_mul(input logic [1:0] a, input logic [1:0] b);
        gf4_mul = {(a[1] & b[1]) ^ (a[1] & b[0]) ^ (a[0] & b[1]),
                   (a[1] & b[1]) ^ (a[0] & b[0])};
    endfunction

    // GF(2^2) square, equal to the inverse for nonzero values
    function automatic logic [1:0] gf4_sq(input logic [1:0] a);
        gf4_sq = {a[1], a[1] ^ a[0]};
    endfunction

    // GF(2^4) product over GF(2^2)
    function automatic logic [3:0] gf16_mul(input logic [3:0] a, input logic [3:0] b);
        logic [1:0] hh;
        hh = gf4_mul(a[3:2], b[3:2]);
        gf16_mul = {hh ^ gf4_mul(a[3:2], b[1:0]) ^ gf4_mul(a[1:0], b[3:2]),
                    gf4_mul(hh, NU) ^ gf4_mul(a[1:0], b[1:0])};
    endfunction

    // Picks a constant L with no root of x^2+x+L in GF(2^4)
    function automatic logic [3:0] find_lambda();
        logic [3:0] res;
        logic       found;
        logic       ok;
        res   = 4'h0;
        found = 1'b0;
        for (int l = 1; l < 16; l++) begin
            ok = 1'b1;
            for (int x = 0; x < 16; x++) begin
                if ((gf16_mul(4'(x), 4'(x)) ^ 4'(x)) == 4'(l)) ok = 1'b0;
            end
            if (ok && !found) begin
                res   = 4'(l);
                found = 1'b1;
            end
        end
        find_lambda = res;
    endfunction

    localparam logic [3:0] LAMBDA = find_lambda();

    // GF(2^8) product over GF(2^4)
    function automatic byte_t gf256_mul(input byte_t a, input byte_t b);
        logic [3:0] hh;
        hh = gf16_mul(a[7:4], b[7:4]);
        gf256_mul = {hh ^ gf16_mul(a[7:4], b[3:0]) ^ gf16_mul(a[3:0], b[7:4]),
                     gf16_mul(hh, LAMBDA) ^ gf16_mul(a[3:0], b[3:0])};
    endfunction

    // First tower element that is a root of the AES reduction polynomial
    function automatic byte_t find_beta();
        byte_t c, c2, c3, c4, c8, res;
        logic  found;
        res   = 8'h00;
        found = 1'b0;
        for (int k = 2; k < 256; k++) begin
            c  = 8'(k);
            c2 = gf256_mul(c, c);
            c3 = gf256_mul(c2, c);
            c4 = gf256_mul(c2, c2);
            c8 = gf256_mul(c4, c4);
            if (((c8 ^ c4 ^ c3 ^ c ^ 8'h01) == 8'h00) && !found) begin
                res   = c;
                found = 1'b1;
            end
        end
        find_beta = res;
    endfunction

    // Linear map: XOR of the columns selected by x
    function automatic byte_t mat_apply(input mat_t m, input byte_t x);
        byte_t acc;
        acc = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (x[i]) acc = acc ^ m[8*i +: 8];
        end
        mat_apply = acc;
    endfunction

    // Polynomial basis to tower basis: column i is beta^i
    function automatic mat_t build_iso();
        mat_t  m;
        byte_t pw, beta;
        beta = find_beta();
        pw   = 8'h01;
        m    = '0;
        for (int i = 0; i < 8; i++) begin
            m[8*i +: 8] = pw;
            pw = gf256_mul(pw, beta);
        end
        build_iso = m;
    endfunction

    // Inverse of a bijective linear map, by preimage search per unit vector
    function automatic mat_t invert_map(input mat_t m);
        mat_t  r;
        byte_t e;
        r = '0;
        for (int j = 0; j < 8; j++) begin
            e    = 8'h00;
            e[j] = 1'b1;
            for (int x = 0; x < 256; x++) begin
                if (mat_apply(m, 8'(x)) == e) r[8*j +: 8] = 8'(x);
            end
        end
        invert_map = r;
    endfunction

    // Linear part of the forward affine step
    function automatic byte_t aff_lin(input byte_t x);
        byte_t r;
        for (int i = 0; i < 8; i++)
            r[i] = x[i] ^ x[(i+4)%8] ^ x[(i+5)%8] ^ x[(i+6)%8] ^ x[(i+7)%8];
        aff_lin = r;
    endfunction

    // Linear part of the inverse affine step
    function automatic byte_t aff_inv_lin(input byte_t x);
        byte_t r;
        for (int i = 0; i < 8; i++)
            r[i] = x[(i+2)%8] ^ x[(i+5)%8] ^ x[(i+7)%8];
        aff_inv_lin = r;
    endfunction

    // Forward affine matrix applied after a given map
    function automatic mat_t merge_aff_after(input mat_t m);
        mat_t r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = aff_lin(m[8*i +: 8]);
        merge_aff_after = r;
    endfunction

    // Given map applied after the inverse affine matrix
    function automatic mat_t merge_affinv_before(input mat_t m);
        mat_t  r;
        byte_t e;
        for (int i = 0; i < 8; i++) begin
            e    = 8'h00;
            e[i] = 1'b1;
            r[8*i +: 8] = mat_apply(m, aff_inv_lin(e));
        end
        merge_affinv_before = r;
    endfunction

    localparam mat_t  ISO         = build_iso();
    localparam mat_t  ISO_INV     = invert_map(ISO);
    localparam mat_t  IN_INV_MAT  = merge_affinv_before(ISO);
    localparam byte_t IN_INV_C    = mat_apply(ISO, 8'h05);
    localparam mat_t  OUT_FWD_MAT = merge_aff_after(ISO_INV);
    localparam byte_t OUT_FWD_C   = 8'h63;

endpackage

// File: rtl/gf_lin_map.sv
// Module: constant GF(2) linear map plus constant, y = M*x ^ C.
// Assumes: MATRIX holds columns as in aes_tower_pkg (column i at bits 8*i).
module gf_lin_map
    import aes_tower_pkg::*;
#(
    parameter int   WIDTH  = 8,
    parameter mat_t MATRIX = '0,
    parameter byte_t OFFSET = '0
) (
    input  logic [WIDTH-1:0] x,
    output logic [WIDTH-1:0] y
);
    logic [WIDTH-1:0] acc [WIDTH+1];

    assign acc[0] = OFFSET;

    // One XOR stage per input bit, adding that bit's column
    for (genvar i = 0; i < WIDTH; i++) begin : g_col
        assign acc[i+1] = acc[i] ^ (x[i] ? MATRIX[WIDTH*i +: WIDTH] : '0);
    end

    assign y = acc[WIDTH];
endmodule

// File: rtl/gf16_inv.sv
// Module: GF(2^4) inverter over GF(2^2), mapping zero to zero.
// Assumes: z^2+z+NU field polynomial, inputs in tower layout.
module gf16_inv
    import aes_tower_pkg::*;
(
    input  logic [3:0] a,
    output logic [3:0] y
);
    logic [1:0] d, d_inv;

    // Subfield norm, its inverse, and the two output halves
    always_comb begin
        d     = gf4_mul(gf4_mul(a[3:2], a[3:2]), NU) ^ gf4_mul(a[3:2], a[1:0])
              ^ gf4_mul(a[1:0], a[1:0]);
        d_inv = gf4_sq(d);
        y     = {gf4_mul(a[3:2], d_inv), gf4_mul(a[3:2] ^ a[1:0], d_inv)};
    end

    // Subfield inverse property
    always_comb begin
        if (!$isunknown(a)) begin
            if (a == 4'h0) begin
                p_sub_zero_r7: assert (y == 4'h0) else $error("subfield inverse of zero not zero");
            end else begin
                p_sub_inv_r7: assert (gf16_mul(a, y) == 4'h1) else $error("subfield inverse wrong");
            end
        end
    end
endmodule

// File: rtl/gf256_inv.sv
// Module: GF(2^8) inverter in the tower field, mapping zero to zero.
// Assumes: y^2+y+LAMBDA field polynomial, byte in tower layout.
module gf256_inv
    import aes_tower_pkg::*;
(
    input  byte_t a,
    output byte_t y
);
    logic [3:0] norm, norm_inv;

    // Exponentiation stage: reduce the element to one GF(2^4) value
    always_comb begin
        norm = gf16_mul(gf16_mul(a[7:4], a[7:4]), LAMBDA) ^ gf16_mul(a[7:4], a[3:0])
             ^ gf16_mul(a[3:0], a[3:0]);
    end

    gf16_inv u_sub_inv (
        .a (norm),
        .y (norm_inv)
    );

    // Recovery stage: both output halves from the subfield inverse
    always_comb begin
        y = {gf16_mul(a[7:4], norm_inv), gf16_mul(a[7:4] ^ a[3:0], norm_inv)};
    end

    // Shared inverter property
    always_comb begin
        if (!$isunknown(a)) begin
            if (a == 8'h00) begin
                p_inv_zero_r7: assert (y == 8'h00) else $error("inverse of zero not zero");
            end else begin
                p_inv_product_r7: assert (gf256_mul(a, y) == 8'h01) else $error("inverse product not one");
            end
        end
    end
endmodule

// File: rtl/aes_sbox_dual.sv
// Module: combined AES forward/inverse S-box, combinational.
// Assumes: inv_mode = 0 forward, 1 inverse; no clock and no reset, since
// the block holds no state; the caller registers around it.
module aes_sbox_dual
    import aes_tower_pkg::*;
(
    input  logic [7:0] din,
    input  logic       inv_mode,
    output logic [7:0] dout
);
    byte_t fwd_in, inv_in, tower_in, tower_inv, fwd_out, inv_out;

    // Forward entry: basis change only
    gf_lin_map #(.MATRIX(ISO), .OFFSET(8'h00)) u_map_in_fwd (
        .x (din),
        .y (fwd_in)
    );

    // Inverse entry: inverse affine merged with basis change
    gf_lin_map #(.MATRIX(IN_INV_MAT), .OFFSET(IN_INV_C)) u_map_in_inv (
        .x (din),
        .y (inv_in)
    );

    // Direction select ahead of the shared inverter
    always_comb tower_in = inv_mode ? inv_in : fwd_in;

    gf256_inv u_inv (
        .a (tower_in),
        .y (tower_inv)
    );

    // Forward exit: basis change back merged with affine step
    gf_lin_map #(.MATRIX(OUT_FWD_MAT), .OFFSET(OUT_FWD_C)) u_map_out_fwd (
        .x (tower_inv),
        .y (fwd_out)
    );

    // Inverse exit: basis change back only
    gf_lin_map #(.MATRIX(ISO_INV), .OFFSET(8'h00)) u_map_out_inv (
        .x (tower_inv),
        .y (inv_out)
    );

    // Direction select at the output
    always_comb dout = inv_mode ? inv_out : fwd_out;

    // Fixed corner points of both directions
    always_comb begin
        if (!$isunknown({inv_mode, din})) begin
            if (!inv_mode && din == 8'h00) begin
                p_fwd_zero_r3: assert (dout == 8'h63) else $error("forward 00 wrong");
            end
            if (inv_mode && din == 8'h63) begin
                p_inv_fixed_r4: assert (dout == 8'h00) else $error("inverse 63 wrong");
            end
        end
    end
endmodule

// File: tb/aes_sbox_dual_test.sv
module aes_sbox_dual_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic       clk = 1'b0;
    logic [7:0] din = 8'h00;
    logic       inv_mode = 1'b0;
    logic [7:0] dout;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [7:0] fwd_tab [256];
    logic [7:0] inv_tab [256];

    aes_sbox_dual uut (
        .din      (din),
        .inv_mode (inv_mode),
        .dout     (dout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG_CYCLES && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG_CYCLES);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Polynomial-basis multiply modulo x^8+x^4+x^3+x+1
    function automatic logic [7:0] pmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r, t;
        r = 8'h00;
        t = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r = r ^ t;
            t = {t[6:0], 1'b0} ^ (t[7] ? 8'h1b : 8'h00);
        end
        pmul = r;
    endfunction

    function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
        rotl = (v << n) | (v >> (8 - n));
    endfunction

    task automatic build_tables();
        logic [7:0] inv, s;
        for (int a = 0; a < 256; a++) begin
            inv = 8'h00;
            for (int b = 1; b < 256; b++)
                if (pmul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
            s = inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ 8'h63;
            fwd_tab[a] = s;
            inv_tab[s] = 8'(a);
        end
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: din=%02h mode=%0b actual %02h expected %02h", req, din, inv_mode, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] b, input logic m);
        @(negedge clk);
        din      = b;
        inv_mode = m;
        #(CLK_PERIOD/4);
    endtask

    initial begin
        logic [7:0] held, fwd_v;
        build_tables();

        // R3: forward of zero
        apply(8'h00, 1'b0);
        check("R3", dout, 8'h63);
        // R4: inverse of 0x63
        apply(8'h63, 1'b1);
        check("R4", dout, 8'h00);

        // R1: full forward sweep
        for (int x = 0; x < 256; x++) begin
            apply(8'(x), 1'b0);
            check("R1", dout, fwd_tab[x]);
        end
        // R2: full inverse sweep, descending order
        for (int x = 255; x >= 0; x--) begin
            apply(8'(x), 1'b1);
            check("R2", dout, inv_tab[x]);
        end

        // R8: same byte, only the direction bit changes
        for (int x = 0; x < 256; x += 17) begin
            apply(8'(x), 1'b0);
            check("R8", dout, fwd_tab[x]);
            apply(8'(x), 1'b1);
            check("R8", dout, inv_tab[x]);
        end

        // R6: forward result fed back in inverse mode
        for (int x = 0; x < 256; x++) begin
            apply(8'(x), 1'b0);
            fwd_v = dout;
            apply(fwd_v, 1'b1);
            check("R6", dout, 8'(x));
        end

        // R5: held inputs keep the output across many clock edges
        apply(8'h53, 1'b0);
        held = dout;
        check("R5", held, fwd_tab[8'h53]);
        repeat (5) @(posedge clk);
        #(CLK_PERIOD/4);
        check("R5", dout, held);
        apply(8'hed, 1'b1);
        apply(8'h53, 1'b0);
        check("R5", dout, held);

        // R7: the inverter zero case seen at the ports in both directions
        apply(8'h00, 1'b0);
        check("R7", dout, 8'h63);
        apply(8'h63, 1'b1);
        check("R7", dout, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule